// File: doc/BRIEF.md
# Sequential Significand Multiplier with Sticky Collapse

This unit forms the product of two normalized binary significands, each with its leading (hidden) bit set, for a fused multiply-add datapath. One narrow multiplier, half the width of the aligned operand word, is reused over four consecutive cycles. The block keeps only the upper half of the double-width product and folds every lower bit into a single sticky bit. It then does a one-bit normalization to a significand that is three bits wider than the input, leaving room for guard, round and sticky.

Alongside the significand, the unit returns the sum of the two operand exponents, plus one when normalization shifts by the extra position. It also returns the product sign, which can be inverted for the subtract form of the fused operation. Bias handling and rounding are left to the stages that follow. A caller pulses `start` while the unit is idle, waits for the one-cycle `done` pulse, and reads results that stay stable until the next accepted start.

Top module: `sigmul_seq`

## Requirements
- R1: After reset, `busy` and `done` are low and `res_sig`, `res_exp` and `res_sign` are zero.
- R2: A `start` sampled high on a clock edge while `busy` is low is accepted, and `busy` is high for the following five cycles.
- R3: `done` is high for exactly one cycle, beginning five clock edges after the accepting edge, and `busy` is low whenever `done` is high.
- R4: Both significands are placed at the top of a word twice the half width (8 zero bits below a 24-bit value by default). The full product of the two aligned words is split into an upper and a lower word. The unit works from the upper word with its bit 0 ORed with "lower word nonzero".
- R5: When bit 31 of that collapsed word is set, `res_sig` is its bits 31..5 with bit 0 ORed with "any of bits 4..0 set", and `res_exp` is the exponent sum plus one.
- R6: When bit 31 is clear, `res_sig` is bits 30..4 of the collapsed word with bit 0 ORed with "any of bits 3..0 set", and `res_exp` equals the exponent sum.
- R7: Bit 26 (the top bit) of `res_sig` is set in every result.
- R8: The exponent sum is the signed sum `x_exp + y_exp`, one bit wider than the inputs.
- R9: `res_sign` is `x_sign XOR y_sign`, inverted when `negate` is high at the accepting edge.
- R10: A `start` received while `busy` is high is ignored. Operand inputs that change during the operation do not affect its result.
- R11: Results hold their values until the operation following the next accepted start completes, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication |
| x_sig | input | 24 | First significand, hidden bit at the top |
| y_sig | input | 24 | Second significand, hidden bit at the top |
| x_exp | input | 10 | First exponent, signed |
| y_exp | input | 10 | Second exponent, signed |
| x_sign | input | 1 | First operand sign |
| y_sign | input | 1 | Second operand sign |
| negate | input | 1 | Invert the product sign |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_sig | output | 27 | Normalized product significand with guard, round and sticky |
| res_exp | output | 11 | Exponent sum, adjusted by normalization, signed |
| res_sign | output | 1 | Product sign |

## Verification
The assertion that the top product bits cannot both be clear, and the one that the result's leading bit is set, rest on both significands arriving with their top bit set. Every vector the stimulus applies ORs the leading bit into its operands, both for the corner patterns and for the pseudo-random ones. The exponent checks assume the one-bit-wider sum cannot overflow, and the bench draws exponents from the full signed input range, which never reaches that limit. The stimulus raises `start` while `busy` is high only to probe the ignore rule, never as a real request.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_NORM = 2'd2
  } sm_state_e;

  // Partial-product issue order; the accumulation depends on it.
  typedef enum logic [1:0] {
    PP_LOLO = 2'd0,
    PP_HIHI = 2'd1,
    PP_LOHI = 2'd2,
    PP_HILO = 2'd3
  } pp_sel_e;

endpackage

// File: rtl/sigmul_rst_sync.sv
module sigmul_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/sigmul_ctrl.sv
module sigmul_ctrl
  import sigmul_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output logic    busy,
  output logic    done,
  output logic    load,
  output logic    acc_en,
  output pp_sel_e sel,
  output logic    ld_out
);

  sm_state_e  state_q, state_d;
  logic [1:0] step_q, step_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ACC;
          step_d  = 2'd0;
        end
      end
      ST_ACC: begin
        step_d = step_q + 2'd1;
        if (step_q == 2'd3) state_d = ST_NORM;
      end
      ST_NORM: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign load   = start && (state_q == ST_IDLE);
  assign acc_en = (state_q == ST_ACC);
  assign sel    = pp_sel_e'(step_q);
  assign ld_out = (state_q == ST_NORM);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

endmodule

// File: rtl/sigmul_operands.sv
module sigmul_operands #(
  parameter int SIG_W  = 24,
  parameter int HALF_W = 16,
  parameter int EXP_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    busy,
  input  logic                    start,
  input  logic [SIG_W-1:0]        x_sig,
  input  logic [SIG_W-1:0]        y_sig,
  input  logic signed [EXP_W-1:0] x_exp,
  input  logic signed [EXP_W-1:0] y_exp,
  input  logic                    x_sign,
  input  logic                    y_sign,
  input  logic                    negate,
  output logic [HALF_W-1:0]       x_hi,
  output logic [HALF_W-1:0]       x_lo,
  output logic [HALF_W-1:0]       y_hi,
  output logic [HALF_W-1:0]       y_lo,
  output logic signed [EXP_W:0]   exp_sum,
  output logic                    prod_sign
);

  localparam int WORD_W   = 2 * HALF_W;
  localparam int ALIGN_SH = WORD_W - SIG_W;

  logic [WORD_W-1:0]     xw_q, xw_d, yw_q, yw_d;
  logic signed [EXP_W:0] es_q, es_d;
  logic                  sg_q, sg_d;

  always_comb begin
    xw_d = xw_q;
    yw_d = yw_q;
    es_d = es_q;
    sg_d = sg_q;
    if (load) begin
      xw_d = {x_sig, {ALIGN_SH{1'b0}}};
      yw_d = {y_sig, {ALIGN_SH{1'b0}}};
      es_d = $signed({x_exp[EXP_W-1], x_exp}) + $signed({y_exp[EXP_W-1], y_exp});
      sg_d = x_sign ^ y_sign ^ negate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xw_q <= '0;
      yw_q <= '0;
      es_q <= '0;
      sg_q <= 1'b0;
    end else begin
      xw_q <= xw_d;
      yw_q <= yw_d;
      es_q <= es_d;
      sg_q <= sg_d;
    end
  end

  assign x_hi      = xw_q[WORD_W-1:HALF_W];
  assign x_lo      = xw_q[HALF_W-1:0];
  assign y_hi      = yw_q[WORD_W-1:HALF_W];
  assign y_lo      = yw_q[HALF_W-1:0];
  assign exp_sum   = es_q;
  assign prod_sign = sg_q;

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(xw_q) && $stable(yw_q) && $stable(es_q) && $stable(sg_q))); // R10

endmodule

// File: rtl/sigmul_accum.sv
module sigmul_accum
  import sigmul_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  pp_sel_e               sel,
  input  logic [HALF_W-1:0]     x_hi,
  input  logic [HALF_W-1:0]     x_lo,
  input  logic [HALF_W-1:0]     y_hi,
  input  logic [HALF_W-1:0]     y_lo,
  output logic [2*HALF_W-1:0]   acc_hi,
  output logic [2*HALF_W-1:0]   acc_lo
);

  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] op_a, op_b;
  logic [WORD_W-1:0] pp;
  logic [WORD_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [WORD_W:0]   lo_sum;

  // Single shared multiplier, operands picked by the issue slot.
  always_comb begin
    case (sel)
      PP_LOLO: begin op_a = x_lo; op_b = y_lo; end
      PP_HIHI: begin op_a = x_hi; op_b = y_hi; end
      PP_LOHI: begin op_a = x_lo; op_b = y_hi; end
      default: begin op_a = x_hi; op_b = y_lo; end
    endcase
  end

  assign pp     = WORD_W'(op_a) * WORD_W'(op_b);
  assign lo_sum = {1'b0, lo_q} + {1'b0, pp[HALF_W-1:0], {HALF_W{1'b0}}};

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (acc_en) begin
      case (sel)
        PP_LOLO: lo_d = pp;
        PP_HIHI: hi_d = pp;
        default: begin
          lo_d = lo_sum[WORD_W-1:0];
          hi_d = hi_q + WORD_W'(lo_sum[WORD_W])
               + {{HALF_W{1'b0}}, pp[WORD_W-1:HALF_W]};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign acc_hi = hi_q;
  assign acc_lo = lo_q;

endmodule

// File: rtl/sigmul_norm.sv
module sigmul_norm #(
  parameter int WORD_W = 32,
  parameter int OUT_W  = 27,
  parameter int EXPS_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic [WORD_W-1:0]        acc_hi,
  input  logic [WORD_W-1:0]        acc_lo,
  input  logic signed [EXPS_W-1:0] exp_in,
  input  logic                     sign_in,
  output logic [OUT_W-1:0]         sig_o,
  output logic signed [EXPS_W-1:0] exp_o,
  output logic                     sign_o
);

  localparam int SH_WIDE   = WORD_W - OUT_W;
  localparam int SH_NARROW = SH_WIDE - 1;

  logic [WORD_W-1:0]        rm;
  logic [OUT_W-1:0]         sig_n, sig_q, sig_d;
  logic signed [EXPS_W-1:0] exp_n, exp_q, exp_d;
  logic                     sgn_q, sgn_d;

  assign rm = acc_hi | {{(WORD_W-1){1'b0}}, |acc_lo};

  always_comb begin
    if (rm[WORD_W-1]) begin
      sig_n = rm[WORD_W-1 -: OUT_W] | {{(OUT_W-1){1'b0}}, |rm[SH_WIDE-1:0]};
      exp_n = exp_in + EXPS_W'(1);
    end else begin
      sig_n = rm[WORD_W-2 -: OUT_W] | {{(OUT_W-1){1'b0}}, |rm[SH_NARROW-1:0]};
      exp_n = exp_in;
    end
  end

  always_comb begin
    sig_d = sig_q;
    exp_d = exp_q;
    sgn_d = sgn_q;
    if (ld) begin
      sig_d = sig_n;
      exp_d = exp_n;
      sgn_d = sign_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
      exp_q <= '0;
      sgn_q <= 1'b0;
    end else begin
      sig_q <= sig_d;
      exp_q <= exp_d;
      sgn_q <= sgn_d;
    end
  end

  assign sig_o  = sig_q;
  assign exp_o  = exp_q;
  assign sign_o = sgn_q;

  AST_PRODUCT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (acc_hi[WORD_W-1] || acc_hi[WORD_W-2])); // R4
  AST_LEAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> sig_o[OUT_W-1]); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(sig_o) && $stable(exp_o) && $stable(sign_o))); // R11

endmodule

// File: rtl/sigmul_seq.sv
module sigmul_seq
  import sigmul_pkg::*;
#(
  parameter int SIG_W  = 24,
  parameter int HALF_W = 16,
  parameter int EXP_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    start,
  input  logic [SIG_W-1:0]        x_sig,
  input  logic [SIG_W-1:0]        y_sig,
  input  logic signed [EXP_W-1:0] x_exp,
  input  logic signed [EXP_W-1:0] y_exp,
  input  logic                    x_sign,
  input  logic                    y_sign,
  input  logic                    negate,
  output logic                    busy,
  output logic                    done,
  output logic [SIG_W+2:0]        res_sig,
  output logic signed [EXP_W:0]   res_exp,
  output logic                    res_sign
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int OUT_W  = SIG_W + 3;

  logic              rst_n;
  logic              load, acc_en, ld_out;
  pp_sel_e           sel;
  logic [HALF_W-1:0] x_hi, x_lo, y_hi, y_lo;
  logic signed [EXP_W:0] exp_sum;
  logic              prod_sign;
  logic [WORD_W-1:0] acc_hi, acc_lo;

  sigmul_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  sigmul_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .load   (load),
    .acc_en (acc_en),
    .sel    (sel),
    .ld_out (ld_out)
  );

  sigmul_operands #(.SIG_W(SIG_W), .HALF_W(HALF_W), .EXP_W(EXP_W)) u_ops (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .busy      (busy),
    .start     (start),
    .x_sig     (x_sig),
    .y_sig     (y_sig),
    .x_exp     (x_exp),
    .y_exp     (y_exp),
    .x_sign    (x_sign),
    .y_sign    (y_sign),
    .negate    (negate),
    .x_hi      (x_hi),
    .x_lo      (x_lo),
    .y_hi      (y_hi),
    .y_lo      (y_lo),
    .exp_sum   (exp_sum),
    .prod_sign (prod_sign)
  );

  sigmul_accum #(.HALF_W(HALF_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (acc_en),
    .sel    (sel),
    .x_hi   (x_hi),
    .x_lo   (x_lo),
    .y_hi   (y_hi),
    .y_lo   (y_lo),
    .acc_hi (acc_hi),
    .acc_lo (acc_lo)
  );

  sigmul_norm #(.WORD_W(WORD_W), .OUT_W(OUT_W), .EXPS_W(EXP_W + 1)) u_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_out),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo),
    .exp_in  (exp_sum),
    .sign_in (prod_sign),
    .sig_o   (res_sig),
    .exp_o   (res_exp),
    .sign_o  (res_sign)
  );

endmodule

// File: tb/sigmul_seq_tb.sv
module sigmul_seq_tb;

  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              start;
  logic [23:0]       x_sig, y_sig;
  logic signed [9:0] x_exp, y_exp;
  logic              x_sign, y_sign, negate;
  logic              busy, done;
  logic [26:0]       res_sig;
  logic signed [10:0] res_exp;
  logic              res_sign;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sigmul_seq u_dut (
    .clk(clk), .rst_ni(rst_ni), .start(start),
    .x_sig(x_sig), .y_sig(y_sig), .x_exp(x_exp), .y_exp(y_exp),
    .x_sign(x_sign), .y_sign(y_sign), .negate(negate),
    .busy(busy), .done(done), .res_sig(res_sig), .res_exp(res_exp),
    .res_sign(res_sign)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One full operation; optionally pokes start and operands while busy.
  task automatic run_op(input logic [23:0] a, input logic [23:0] b,
                        input logic signed [9:0] ea, input logic signed [9:0] eb,
                        input bit sa, input bit sb, input bit ng, input bit poke);
    logic [63:0] p;
    logic [31:0] rm;
    logic [26:0] esig;
    int          eexp;
    bit          esgn;
    logic [26:0] held_sig;
    p  = ({40'd0, a} << 8) * ({40'd0, b} << 8);
    rm = p[63:32] | {31'd0, (p[31:0] != 0)};
    if (rm[31]) begin
      esig = 27'(rm >> 5) | {26'd0, (rm[4:0] != 0)};   // R5
      eexp = int'(ea) + int'(eb) + 1;
    end else begin
      esig = 27'(rm >> 4) | {26'd0, (rm[3:0] != 0)};   // R6
      eexp = int'(ea) + int'(eb);                      // R8
    end
    esgn = sa ^ sb ^ ng;                               // R9
    x_sig = a; y_sig = b; x_exp = ea; y_exp = eb;
    x_sign = sa; y_sign = sb; negate = ng; start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    for (int k = 1; k <= 4; k++) begin
      if (poke && k == 2) begin
        start = 1'b1; x_sig = ~a; y_sig = 24'hFFFFFF; x_exp = ~ea;
        x_sign = ~sa; negate = ~ng;
      end
      tick();
      if (poke && k == 3) start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R2 busy window", {62'd0, busy, done}, 64'd2);
    end
    tick();
    chk(done === 1'b1 && busy === 1'b0, "R3 done timing", {62'd0, busy, done}, 64'd1);
    chk(res_sig === esig, poke ? "R10 sig after busy start" : (rm[31] ? "R5 sig" : "R6 sig"),
        64'(res_sig), 64'(esig));
    chk(int'(res_exp) == eexp, rm[31] ? "R5 exp" : "R8 exp", 64'(res_exp), 64'(eexp));
    chk(res_sign === esgn, "R9 sign", 64'(res_sign), 64'(esgn));
    chk(res_sig[26] === 1'b1, "R7 lead bit", 64'(res_sig[26]), 64'd1);
    held_sig = res_sig;
    x_sig = 24'h800001; y_sig = 24'hC00000; negate = ~negate;
    tick();
    chk(done === 1'b0, "R3 done single pulse", 64'(done), 64'd0);
    chk(res_sig === held_sig && res_sign === esgn, "R11 hold",
        64'(res_sig), 64'(held_sig));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] corner [10];
    corner[0] = 24'h800000; corner[1] = 24'hFFFFFF; corner[2] = 24'hC00000;
    corner[3] = 24'h800001; corner[4] = 24'hAAAAAA; corner[5] = 24'hD55555;
    corner[6] = 24'hB504F3; corner[7] = 24'hB504F4; corner[8] = 24'hFFFF00;
    corner[9] = 24'h8000FF;
    rst_ni = 1'b0; start = 1'b0; x_sig = '0; y_sig = '0; x_exp = '0; y_exp = '0;
    x_sign = 1'b0; y_sign = 1'b0; negate = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0, "R1 control reset", {62'd0, busy, done}, 64'd0);
    chk(res_sig === 27'd0 && res_exp === 11'sd0 && res_sign === 1'b0, "R1 result reset",
        64'(res_sig), 64'd0);
    // R10 start while busy with changed operands
    run_op(24'hC00000, 24'hC00000, 10'sd5, -10'sd3, 1'b1, 1'b0, 1'b0, 1'b1);
    // Extreme exponents for R8
    run_op(24'hFFFFFF, 24'hFFFFFF, 10'sd511, 10'sd511, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(24'h800000, 24'h800000, -10'sd512, -10'sd512, 1'b1, 1'b1, 1'b1, 1'b0);
    // Corner cross product; sticky and both normalization paths (R4, R5, R6)
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        run_op(corner[i], corner[j], 10'(i * 37 - 200), 10'(j * 51 - 250),
               i[0], j[1], i[2] ^ j[0], (i + j) % 7 == 0);
    // Pseudo-random sweep with hidden bit forced
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r1, r2;
      r1 = $urandom;
      r2 = $urandom;
      run_op(24'h800000 | r1[23:0], 24'h800000 | r2[23:0], 10'(r1[31:22]), 10'(r2[31:22]),
             r1[0], r2[0], r1[1], n % 13 == 0);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule